// File: doc/BRIEF.md
# External Interrupt Detector with Noise Filter

This block watches four external interrupt pins of a small 8-bit controller. Each pin first passes through a synchroniser. It then reaches its own trigger channel, which applies the trigger mode chosen for that pin and holds a pending flag. An enable bit per channel turns a pending flag into a request. When at least one request is active, the block presents a fixed vector address to the CPU. If several requests are active together, the lowest-numbered channel wins. A one-cycle acknowledge from the CPU clears the pending flag of the vector being served.

Channel 3 has an extra noise rejection filter. It samples the synchronised pin on a prescaled copy of the instruction-cycle strobe `cyc_tick`, and the prescale is selected by register. The output of the filter feeds channel 3 and also drives a one-cycle event strobe meant for a timer event counter. Software configures the block through a small register port with four word addresses:

- address 0 holds the trigger modes;
- address 1 holds the enables;
- address 2 holds the pending flags (write 1 to clear);
- address 3 holds the filter divider select.

Top module: `ext_irq_unit`

## Requirements
- R1: After reset, every register reads zero, `irq_valid` is 0, `irq_vec` is 8'h00 and `tmr_evt` is 0.
- R2: The trigger mode of channel i is the 3-bit field [3i+2:3i] at address 0. The codes are 0 off, 1 rising, 2 falling, 3 both edges, 4 high level and 5 low level. Channels 0 and 1 reject code 3, and channels 2 and 3 reject codes 4 and 5. Codes 6 and 7 are rejected everywhere. A rejected code is stored, and read back, as 0.
- R3: The vector is 8'h03 for channel 0, 8'h0B for channel 1, 8'h13 for channel 2 and 8'h1B for channel 3. `irq_vec` is 8'h00 whenever `irq_valid` is 0.
- R4: When several requests are active together, the lowest-numbered channel is presented.
- R5: In an edge mode, the pending flag (address 2, bit i) is set by the selected edge of the synchronised pin, whether or not the channel is enabled.
- R6: An edge pending flag is cleared by `ack` only when its channel is the one being presented. It is also cleared by writing 1 to its bit at address 2. Pending flags of other channels are kept.
- R7: In a level mode, the pending bit equals the live level match and the request follows the pin while the channel is enabled. `ack` has no effect on it.
- R8: The channel 3 filter changes its output only when two consecutive samples agree. Samples are taken on every `cyc_tick` when select (address 3, bits [1:0]) is 0, on every 16th when it is 1, and on every 64th when it is 2 or 3. The minimum accepted pulse is therefore 2, 32 or 128 ticks.
- R9: `tmr_evt` is a single-cycle pulse on each rising edge of the filtered channel 3 signal.
- R10: A pending flag whose enable bit (address 1, bit i) is 0 does not raise `irq_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cyc_tick | input | 1 | Instruction-cycle strobe, one clock wide |
| irq_pin | input | 4 | Raw external interrupt pins |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | 16 | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | 16 | Register read data (combinational) |
| ack | input | 1 | CPU acknowledge of the presented vector |
| irq_valid | output | 1 | At least one enabled request is active |
| irq_vec | output | 8 | Vector address of the winning channel |
| tmr_evt | output | 1 | Timer event strobe from the filtered channel 3 |

## Verification
The bench builds the block with its default parameters: a two-flop synchroniser and filter dividers of 16 and 64. With these values, both the middle and the slow filter settings can be exercised on pulses just below and just above the accepted width, within a few hundred cycles. `cyc_tick` is held high, so the filter widths are measured directly in clocks. The default register width leaves room for all four 3-bit mode fields, so every channel can be checked against every legal and illegal trigger code.

// File: rtl/irq_pkg.sv
package irq_pkg;

  typedef enum logic [2:0] {
    TRG_OFF  = 3'd0,
    TRG_RISE = 3'd1,
    TRG_FALL = 3'd2,
    TRG_BOTH = 3'd3,
    TRG_HIGH = 3'd4,
    TRG_LOW  = 3'd5
  } trig_e;

  localparam int unsigned NUM_SRC    = 4;
  localparam int unsigned MODE_W     = 3;
  localparam int unsigned VEC_W      = 8;
  localparam int unsigned VEC_BASE   = 3;
  localparam int unsigned VEC_STRIDE = 8;

  // Map a requested trigger code to the one the channel can honour.
  function automatic logic [MODE_W-1:0] legal_mode(input logic [MODE_W-1:0] m,
                                                   input logic lvl_ok,
                                                   input logic both_ok);
    logic [MODE_W-1:0] r;
    case (m)
      TRG_RISE, TRG_FALL: r = m;
      TRG_BOTH:           r = both_ok ? m : TRG_OFF;
      TRG_HIGH, TRG_LOW:  r = lvl_ok ? m : TRG_OFF;
      default:            r = TRG_OFF;
    endcase
    return r;
  endfunction

  function automatic logic [VEC_W-1:0] vec_of(input int unsigned idx);
    return VEC_W'(VEC_BASE + VEC_STRIDE * idx);
  endfunction

endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  always_comb begin
    sh_d = {sh_q[STAGES-2:0], d};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign q = sh_q[STAGES-1];
endmodule

// File: rtl/irq_noise_filter.sv
module irq_noise_filter #(
  parameter int unsigned DIV_MID  = 16,
  parameter int unsigned DIV_SLOW = 64
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cyc_tick,
  input  logic [1:0] sel,
  input  logic       din,
  output logic       dout,
  output logic       samp_en
);
  localparam int unsigned CNT_W = (DIV_SLOW > 1) ? $clog2(DIV_SLOW) : 1;

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] lim;
  logic             last_q, last_d;
  logic             out_q, out_d;
  logic             wrap;

  always_comb begin
    case (sel)
      2'd0:    lim = '0;
      2'd1:    lim = CNT_W'(DIV_MID - 1);
      default: lim = CNT_W'(DIV_SLOW - 1);
    endcase
    wrap    = (cnt_q >= lim);
    samp_en = cyc_tick && wrap;
    cnt_d   = cnt_q;
    if (cyc_tick) cnt_d = wrap ? '0 : cnt_q + 1'b1;
    last_d  = last_q;
    out_d   = out_q;
    if (samp_en) begin
      last_d = din;
      if ((din == last_q) && (din != out_q)) out_d = din;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      last_q <= 1'b0;
      out_q  <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      last_q <= last_d;
      out_q  <= out_d;
    end
  end

  assign dout = out_q;
endmodule

// File: rtl/irq_channel.sv
module irq_channel
  import irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              din,
  input  logic [MODE_W-1:0] mode,
  input  logic              en,
  input  logic              clr,
  output logic              pend,
  output logic              req
);
  logic prev_q;
  logic pend_q, pend_d;
  logic rise, fall, hit, is_level, lvl_hit;

  always_comb begin
    rise     = din & ~prev_q;
    fall     = ~din & prev_q;
    is_level = (mode == TRG_HIGH) || (mode == TRG_LOW);
    lvl_hit  = ((mode == TRG_HIGH) && din) || ((mode == TRG_LOW) && !din);
    hit      = ((mode == TRG_RISE) && rise) ||
               ((mode == TRG_FALL) && fall) ||
               ((mode == TRG_BOTH) && (rise || fall));
    if (is_level)  pend_d = 1'b0;
    else if (hit)  pend_d = 1'b1;
    else if (clr)  pend_d = 1'b0;
    else           pend_d = pend_q;
    pend = is_level ? lvl_hit : pend_q;
    req  = pend & en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      prev_q <= din;
      pend_q <= pend_d;
    end
  end
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import irq_pkg::*;
#(
  parameter int unsigned N = 4
) (
  input  logic [N-1:0]         req,
  output logic                 valid,
  output logic [$clog2(N)-1:0] idx,
  output logic [VEC_W-1:0]     vec
);
  localparam int unsigned IDX_W = $clog2(N);

  always_comb begin
    valid = 1'b0;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        valid = 1'b1;
        idx   = IDX_W'(i);
      end
    end
    vec = valid ? vec_of(int'(idx)) : '0;
  end
endmodule

// File: rtl/ext_irq_unit.sv
module ext_irq_unit
  import irq_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned DIV_MID     = 16,
  parameter int unsigned DIV_SLOW    = 64
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cyc_tick,
  input  logic [NUM_SRC-1:0]  irq_pin,
  input  logic                wr_en,
  input  logic [1:0]          wr_addr,
  input  logic [15:0]         wr_data,
  input  logic [1:0]          rd_addr,
  output logic [15:0]         rd_data,
  input  logic                ack,
  output logic                irq_valid,
  output logic [VEC_W-1:0]    irq_vec,
  output logic                tmr_evt
);
  localparam int unsigned IDX_W   = $clog2(NUM_SRC);
  localparam int unsigned MODES_W = NUM_SRC * MODE_W;
  localparam logic [1:0]  ADR_MODE = 2'd0;
  localparam logic [1:0]  ADR_EN   = 2'd1;
  localparam logic [1:0]  ADR_PEND = 2'd2;
  localparam logic [1:0]  ADR_FSEL = 2'd3;
  localparam int unsigned FILT_CH  = NUM_SRC - 1;

  logic [NUM_SRC-1:0][MODE_W-1:0] mode_q, mode_d;
  logic [NUM_SRC-1:0]             en_q, en_d;
  logic [1:0]                     fsel_q, fsel_d;
  logic [NUM_SRC-1:0]             pin_s, chan_in, clr_w, pend_w, req_w;
  logic                           filt_q, filt_prev_q, samp_en;
  logic [IDX_W-1:0]               win_idx;

  // register next state
  always_comb begin
    mode_d = mode_q;
    en_d   = en_q;
    fsel_d = fsel_q;
    if (wr_en) begin
      case (wr_addr)
        ADR_MODE: begin
          for (int i = 0; i < NUM_SRC; i++) begin
            mode_d[i] = legal_mode(wr_data[i*MODE_W +: MODE_W], (i < 2), (i >= 2));
          end
        end
        ADR_EN:   en_d   = wr_data[NUM_SRC-1:0];
        ADR_FSEL: fsel_d = wr_data[1:0];
        default:  ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q      <= '0;
      en_q        <= '0;
      fsel_q      <= '0;
      filt_prev_q <= 1'b0;
    end else begin
      mode_q      <= mode_d;
      en_q        <= en_d;
      fsel_q      <= fsel_d;
      filt_prev_q <= filt_q;
    end
  end

  always_comb begin
    case (rd_addr)
      ADR_MODE: rd_data = 16'(mode_q);
      ADR_EN:   rd_data = 16'(en_q);
      ADR_PEND: rd_data = 16'(pend_w);
      default:  rd_data = 16'(fsel_q);
    endcase
  end

  generate
    for (genvar g = 0; g < NUM_SRC; g++) begin : g_ch
      irq_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(irq_pin[g]), .q(pin_s[g])
      );
      if (g == FILT_CH) begin : g_filt
        irq_noise_filter #(.DIV_MID(DIV_MID), .DIV_SLOW(DIV_SLOW)) u_filt (
          .clk(clk), .rst_n(rst_n), .cyc_tick(cyc_tick), .sel(fsel_q),
          .din(pin_s[g]), .dout(filt_q), .samp_en(samp_en)
        );
        assign chan_in[g] = filt_q;
      end else begin : g_direct
        assign chan_in[g] = pin_s[g];
      end
      assign clr_w[g] = (wr_en && (wr_addr == ADR_PEND) && wr_data[g]) ||
                        (ack && irq_valid && (win_idx == IDX_W'(g)));
      irq_channel u_chan (
        .clk(clk), .rst_n(rst_n), .din(chan_in[g]), .mode(mode_q[g]),
        .en(en_q[g]), .clr(clr_w[g]), .pend(pend_w[g]), .req(req_w[g])
      );
    end
  endgenerate

  irq_arbiter #(.N(NUM_SRC)) u_arb (
    .req(req_w), .valid(irq_valid), .idx(win_idx), .vec(irq_vec)
  );

  assign tmr_evt = filt_q & ~filt_prev_q;

  logic unused_w;
  assign unused_w = ^{wr_data[15:MODES_W]};
endmodule

// File: rtl/ext_irq_unit_chk.sv
module ext_irq_unit_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       ack,
  input logic       wr_en,
  input logic       irq_valid,
  input logic [7:0] irq_vec,
  input logic [3:0] req,
  input logic [3:0] pend,
  input logic       tmr_evt,
  input logic       samp_en,
  input logic       filt
);
  AST_VEC_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |-> (irq_vec == 8'h03 || irq_vec == 8'h0B || irq_vec == 8'h13 || irq_vec == 8'h1B)); // R3

  AST_LOW_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_valid && req[0]) |-> (irq_vec == 8'h03)); // R4

  AST_EDGE_CLEAR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pend[2]) |-> $past(ack || wr_en)); // R6

  AST_FILT_ON_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
    !samp_en |=> $stable(filt)); // R8

  AST_EVT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_evt |=> !tmr_evt); // R9
endmodule

bind ext_irq_unit ext_irq_unit_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ack(ack), .wr_en(wr_en), .irq_valid(irq_valid),
  .irq_vec(irq_vec), .req(req_w), .pend(pend_w), .tmr_evt(tmr_evt),
  .samp_en(samp_en), .filt(filt_q)
);

// File: tb/sim_ext_irq_unit.sv
module sim_ext_irq_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cyc_tick = 1'b1;
  logic [3:0]  irq_pin = '0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [1:0]  rd_addr = '0;
  logic [15:0] rd_data;
  logic        ack = 1'b0;
  logic        irq_valid;
  logic [7:0]  irq_vec;
  logic        tmr_evt;

  int checks = 0;
  int errors = 0;
  int evt_cnt = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  ext_irq_unit u0 (
    .clk(clk), .rst_n(rst_n), .cyc_tick(cyc_tick), .irq_pin(irq_pin),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
    .rd_data(rd_data), .ack(ack), .irq_valid(irq_valid), .irq_vec(irq_vec),
    .tmr_evt(tmr_evt)
  );

  always @(negedge clk) if (tmr_evt) evt_cnt++;

  // entry: [7:6] channel, [5:3] mode code, [2] pin before, [1] pin after, [0] expected pending
  localparam logic [7:0] TBL [10] = '{
    {2'd0, 3'd1, 1'b0, 1'b1, 1'b1},
    {2'd0, 3'd1, 1'b1, 1'b0, 1'b0},
    {2'd0, 3'd2, 1'b1, 1'b0, 1'b1},
    {2'd0, 3'd4, 1'b0, 1'b1, 1'b1},
    {2'd0, 3'd5, 1'b0, 1'b1, 1'b0},
    {2'd1, 3'd5, 1'b1, 1'b0, 1'b1},
    {2'd2, 3'd3, 1'b0, 1'b1, 1'b1},
    {2'd2, 3'd3, 1'b1, 1'b0, 1'b1},
    {2'd2, 3'd1, 1'b1, 1'b0, 1'b0},
    {2'd3, 3'd2, 1'b1, 1'b0, 1'b1}
  };

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    cyc(1);
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] d);
    rd_addr = a;
    #0.1;
    d = rd_data;
  endtask

  task automatic do_ack();
    ack = 1'b1;
    cyc(1);
    ack = 1'b0;
  endtask

  task automatic pulse3(input int n);
    irq_pin[3] = 1'b1;
    cyc(n);
    irq_pin[3] = 1'b0;
    cyc(300);
  endtask

  initial begin
    #(5ns * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    cyc(3);
    rst_n = 1'b1;
    cyc(2);

    // R1 reset state
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), v);
      chk("R1 reg", v, 16'h0);
    end
    chk("R1 valid", 16'(irq_valid), 16'h0);
    chk("R1 vec", 16'(irq_vec), 16'h0);
    chk("R1 evt", 16'(tmr_evt), 16'h0);

    // R5 R7 R8: table of trigger cases, enables off
    for (int e = 0; e < 10; e++) begin
      logic [1:0] ch;
      logic [2:0] md;
      ch = TBL[e][7:6];
      md = TBL[e][5:3];
      irq_pin = '0;
      cyc(12);
      wr(2'd0, 16'(md) << (3 * ch));
      irq_pin[ch] = TBL[e][2];
      cyc(12);
      wr(2'd2, 16'hF);
      irq_pin[ch] = TBL[e][1];
      cyc(12);
      rd(2'd2, v);
      chk("R5/R7 table pending", 16'(v[ch]), 16'(TBL[e][0]));
    end
    irq_pin = '0;
    cyc(12);

    // R2 illegal codes: in0=3, in1=6, in2=4, in3=3 (legal)
    wr(2'd0, 16'(3 | (6 << 3) | (4 << 6) | (3 << 9)));
    rd(2'd0, v);
    chk("R2 legalised modes", v, 16'h0600);

    // R3 R4 R6 R10: all rising
    wr(2'd0, 16'h0249);
    wr(2'd1, 16'h0);
    wr(2'd2, 16'hF);
    irq_pin = 4'hF;
    cyc(12);
    rd(2'd2, v);
    chk("R5 all pending", v, 16'hF);
    chk("R10 disabled no valid", 16'(irq_valid), 16'h0);
    wr(2'd1, 16'hF);
    chk("R4 lowest wins", 16'(irq_vec), 16'h03);
    do_ack();
    rd(2'd2, v);
    chk("R6 ack clears served only", v, 16'hE);
    chk("R3 vec1", 16'(irq_vec), 16'h0B);
    do_ack();
    chk("R3 vec2", 16'(irq_vec), 16'h13);
    do_ack();
    chk("R3 vec3", 16'(irq_vec), 16'h1B);
    do_ack();
    chk("R3 idle valid", 16'(irq_valid), 16'h0);
    chk("R3 idle vec", 16'(irq_vec), 16'h0);

    // R6 write-one-to-clear
    irq_pin = 4'h0;
    wr(2'd1, 16'h0);
    cyc(12);
    irq_pin = 4'hF;
    cyc(12);
    wr(2'd2, 16'h5);
    rd(2'd2, v);
    chk("R6 w1c", v, 16'hA);
    wr(2'd2, 16'hF);
    irq_pin = 4'h0;
    cyc(12);

    // R7 level high on channel 0
    wr(2'd0, 16'h0004);
    wr(2'd1, 16'h1);
    irq_pin[0] = 1'b1;
    cyc(6);
    chk("R7 level vec", 16'(irq_vec), 16'h03);
    do_ack();
    chk("R7 ack no effect", 16'(irq_valid), 16'h1);
    irq_pin[0] = 1'b0;
    cyc(6);
    chk("R7 level drop", 16'(irq_valid), 16'h0);
    wr(2'd1, 16'h0);

    // R8 filter widths, channel 3 rising
    wr(2'd0, 16'h0200);
    wr(2'd3, 16'h0);
    wr(2'd2, 16'hF); pulse3(1);
    rd(2'd2, v); chk("R8 sel0 1-cycle rejected", 16'(v[3]), 16'h0);
    wr(2'd2, 16'hF); pulse3(3);
    rd(2'd2, v); chk("R8 sel0 3-cycle accepted", 16'(v[3]), 16'h1);
    wr(2'd3, 16'h1);
    wr(2'd2, 16'hF); pulse3(8);
    rd(2'd2, v); chk("R8 sel1 short rejected", 16'(v[3]), 16'h0);
    wr(2'd2, 16'hF); pulse3(40);
    rd(2'd2, v); chk("R8 sel1 long accepted", 16'(v[3]), 16'h1);
    wr(2'd3, 16'h2);
    wr(2'd2, 16'hF); pulse3(60);
    rd(2'd2, v); chk("R8 sel2 short rejected", 16'(v[3]), 16'h0);
    wr(2'd2, 16'hF);
    evt_cnt = 0;
    pulse3(140);
    rd(2'd2, v); chk("R8 sel2 long accepted", 16'(v[3]), 16'h1);
    chk("R9 one event strobe", 16'(evt_cnt), 16'h1);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule